// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the control and status register of a two-wire serial channel that uses release and command signalling on its data line. Software reaches it over a plain CPU bus. A byte write loads the whole register. A single-bit write picks one bit by index and sets or clears it. Three trigger bits act as one-shot commands: one drives the serial output latch high, one drives it low, and one asks for an acknowledge on the serial clock. None of them is stored, so each always reads back as zero.

Two sticky status flags capture pulses from the line detectors outside this block: a bus release seen and a command seen. Each flag has its own clear sources, such as a transfer start, an address mismatch or the channel being disabled. The acknowledge request waits for the next falling edge of the serial clock. It then holds the acknowledge line low for one serial clock period. All state is registered on the system clock, and serial clock falling edges arrive as single-cycle strobes.

Top module: `sbus_ctrl_reg`

## Requirements
- R1: After reset, every stored bit is 0, so `rdData` is 0x00 while `ackDet` is low. `soLatch` is 1 and `ackLineN` is 1.
- R2: A write with bit 0 (release trigger) equal to 1 while `chanEn` is 1 and bit 1 not also set makes `soLatch` 1 from the next cycle on.
- R3: A write with bit 1 (command trigger) equal to 1 while `chanEn` is 1 makes `soLatch` 0 from the next cycle on. When both trigger bits are written in one byte, the command trigger wins.
- R4: While `chanEn` is 0, writes to trigger bits 0, 1 and 4 have no effect. `soLatch` keeps its value, no acknowledge is queued, and `ackLineN` returns to 1 on the next cycle.
- R5: Read bit 2 (release seen) becomes 1 the cycle after a `relSeen` pulse. It becomes 0 the cycle after `xferStart`, `addrMiss` or `chanEn`=0, and a clear wins over a set in the same cycle.
- R6: Read bit 3 (command seen) becomes 1 the cycle after a `cmdSeen` pulse. It becomes 0 the cycle after `xferStart`, `relSeen` or `chanEn`=0, and a clear wins over a set. A `relSeen` pulse therefore sets bit 2 and clears bit 3 together.
- R7: After bit 4 (acknowledge trigger) is written to 1 with `chanEn` high, the first `sclkFall` in a later cycle drives `ackLineN` low. The following `sclkFall` releases it. An `xferStart` before that first falling edge cancels the request.
- R8: `rdData` is {bit7 busy-enable, bit6 `ackDet`, bit5 ack-enable, bit4 0, bit3 command seen, bit2 release seen, bit1 0, bit0 0}. Writes to bits 6, 3 and 2 have no effect.
- R9: Bits 7 and 5 are plain storage, writable whatever `chanEn` is. A single-bit write changes only the indexed bit. Clearing a trigger bit does nothing. A byte write in the same cycle takes precedence over a single-bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEn | input | 1 | Serial channel enable |
| wrByte | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte write data |
| bitWr | input | 1 | Single-bit write strobe |
| bitIdx | input | 3 | Bit index for single-bit write |
| bitVal | input | 1 | Value for single-bit write (1 set, 0 clear) |
| xferStart | input | 1 | Transfer start pulse |
| relSeen | input | 1 | Bus release detected pulse |
| cmdSeen | input | 1 | Command detected pulse |
| addrMiss | input | 1 | Address mismatch during address reception pulse |
| sclkFall | input | 1 | Serial clock falling edge strobe |
| ackDet | input | 1 | Acknowledge detected status, read on bit 6 |
| rdData | output | 8 | Register read value |
| soLatch | output | 1 | Serial output data latch |
| ackLineN | output | 1 | Acknowledge drive, active low |

## Verification
The following properties are checked on every cycle:
- Each trigger write moves the output latch in the required direction.
- The latch holds whenever no trigger is written.
- Each clear source empties its status flag, and each unopposed detection pulse sets it.
- The acknowledge line changes only on a serial falling edge or on disable.

The bench's scenarios show what the cycle properties cannot: the whole acknowledge sequence across two falling edges, a transfer start cancelling a queued acknowledge, and the byte-over-bit write precedence.

// File: rtl/sbus_ctrl_pkg.sv
package sbus_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int IDX_W = $clog2(REG_W);

  // Bit positions; software decodes these, so they are fixed.
  localparam int B_REL  = 0;
  localparam int B_CMD  = 1;
  localparam int B_RELD = 2;
  localparam int B_CMDD = 3;
  localparam int B_ACKT = 4;
  localparam int B_ACKE = 5;
  localparam int B_ACKD = 6;
  localparam int B_BSYE = 7;

  typedef struct packed {
    logic bsyeWe;
    logic bsyeVal;
    logic ackeWe;
    logic ackeVal;
    logic relTrig;
    logic cmdTrig;
    logic ackReq;
  } ctlStrobe_t;
endpackage

// File: rtl/sbus_ctrl_ctl.sv
module sbus_ctrl_ctl import sbus_ctrl_pkg::*; (
  input  logic             chanEn,
  input  logic             wrByte,
  input  logic [REG_W-1:0] wrData,
  input  logic             bitWr,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             bitVal,
  output ctlStrobe_t       strb
);
  logic [REG_W-1:0] wrMask;
  logic [REG_W-1:0] wrVal;

  // Byte write takes precedence over single-bit write (R9)
  always_comb begin
    wrMask = '0;
    wrVal  = '0;
    if (wrByte) begin
      wrMask = '1;
      wrVal  = wrData;
    end else if (bitWr) begin
      wrMask[bitIdx] = 1'b1;
      wrVal[bitIdx]  = bitVal;
    end
  end

  // Trigger bits only act on a written 1 with the channel enabled (R4)
  always_comb begin
    strb.bsyeWe  = wrMask[B_BSYE];
    strb.bsyeVal = wrVal[B_BSYE];
    strb.ackeWe  = wrMask[B_ACKE];
    strb.ackeVal = wrVal[B_ACKE];
    strb.relTrig = chanEn & wrMask[B_REL]  & wrVal[B_REL];
    strb.cmdTrig = chanEn & wrMask[B_CMD]  & wrVal[B_CMD];
    strb.ackReq  = chanEn & wrMask[B_ACKT] & wrVal[B_ACKT];
  end
endmodule

// File: rtl/sbus_ctrl_dp.sv
module sbus_ctrl_dp import sbus_ctrl_pkg::*; #(
  parameter logic RESET_SO = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  ctlStrobe_t       strb,
  input  logic             xferStart,
  input  logic             relSeen,
  input  logic             cmdSeen,
  input  logic             addrMiss,
  input  logic             sclkFall,
  input  logic             ackDet,
  output logic [REG_W-1:0] rdData,
  output logic             soLatch,
  output logic             ackLineN
);
  logic bsye, acke, reld, cmdd, soQ, ackPend, ackAct;
  logic relClr, cmdClr;

  assign relClr = xferStart | addrMiss | ~chanEn;
  assign cmdClr = xferStart | relSeen  | ~chanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsye    <= 1'b0;
      acke    <= 1'b0;
      reld    <= 1'b0;
      cmdd    <= 1'b0;
      soQ     <= RESET_SO;
      ackPend <= 1'b0;
      ackAct  <= 1'b0;
    end else begin
      if (strb.bsyeWe) bsye <= strb.bsyeVal;
      if (strb.ackeWe) acke <= strb.ackeVal;
      // Command trigger beats release trigger (R3)
      if (strb.cmdTrig)      soQ <= 1'b0;
      else if (strb.relTrig) soQ <= 1'b1;
      // Clear wins over set (R5, R6)
      if (relClr)       reld <= 1'b0;
      else if (relSeen) reld <= 1'b1;
      if (cmdClr)       cmdd <= 1'b0;
      else if (cmdSeen) cmdd <= 1'b1;
      // Acknowledge: queued request moves to the line on a falling edge (R7)
      if (!chanEn)       ackAct <= 1'b0;
      else if (sclkFall) ackAct <= ackPend;
      if (!chanEn || xferStart) ackPend <= 1'b0;
      else if (strb.ackReq)     ackPend <= 1'b1;
      else if (sclkFall)        ackPend <= 1'b0;
    end
  end

  always_comb begin
    rdData         = '0;
    rdData[B_BSYE] = bsye;
    rdData[B_ACKD] = ackDet;
    rdData[B_ACKE] = acke;
    rdData[B_CMDD] = cmdd;
    rdData[B_RELD] = reld;
  end

  assign soLatch  = soQ;
  assign ackLineN = ~ackAct;
endmodule

// File: rtl/sbus_ctrl_reg.sv
module sbus_ctrl_reg import sbus_ctrl_pkg::*; #(
  parameter logic RESET_SO = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrByte,
  input  logic [REG_W-1:0] wrData,
  input  logic             bitWr,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             bitVal,
  input  logic             xferStart,
  input  logic             relSeen,
  input  logic             cmdSeen,
  input  logic             addrMiss,
  input  logic             sclkFall,
  input  logic             ackDet,
  output logic [REG_W-1:0] rdData,
  output logic             soLatch,
  output logic             ackLineN
);
  ctlStrobe_t strb;

  sbus_ctrl_ctl u_ctl (
    .chanEn (chanEn),
    .wrByte (wrByte),
    .wrData (wrData),
    .bitWr  (bitWr),
    .bitIdx (bitIdx),
    .bitVal (bitVal),
    .strb   (strb)
  );

  sbus_ctrl_dp #(.RESET_SO(RESET_SO)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .strb      (strb),
    .xferStart (xferStart),
    .relSeen   (relSeen),
    .cmdSeen   (cmdSeen),
    .addrMiss  (addrMiss),
    .sclkFall  (sclkFall),
    .ackDet    (ackDet),
    .rdData    (rdData),
    .soLatch   (soLatch),
    .ackLineN  (ackLineN)
  );
endmodule

// File: rtl/sbus_ctrl_chk.sv
module sbus_ctrl_chk import sbus_ctrl_pkg::*; (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             wrByte,
  input logic [REG_W-1:0] wrData,
  input logic             bitWr,
  input logic [IDX_W-1:0] bitIdx,
  input logic             bitVal,
  input logic             xferStart,
  input logic             relSeen,
  input logic             cmdSeen,
  input logic             addrMiss,
  input logic             sclkFall,
  input logic [REG_W-1:0] rdData,
  input logic             soLatch,
  input logic             ackLineN
);
  logic relWr, cmdWr;

  assign relWr = chanEn && ((wrByte && wrData[B_REL]) ||
                 (!wrByte && bitWr && bitVal && bitIdx == IDX_W'(B_REL)));
  assign cmdWr = chanEn && ((wrByte && wrData[B_CMD]) ||
                 (!wrByte && bitWr && bitVal && bitIdx == IDX_W'(B_CMD)));

  p_rel_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    relWr && !cmdWr |=> soLatch);
  p_cmd_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !soLatch);
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !relWr && !cmdWr |=> $stable(soLatch));
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> ackLineN);
  p_reld_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || addrMiss || !chanEn) |=> !rdData[B_RELD]);
  p_reld_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (relSeen && !xferStart && !addrMiss && chanEn) |=> rdData[B_RELD]);
  p_cmdd_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart || relSeen || !chanEn) |=> !rdData[B_CMDD]);
  p_cmdd_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSeen && !xferStart && !relSeen && chanEn) |=> rdData[B_CMDD]);
  p_ack_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ackLineN) |-> ($past(sclkFall) || !$past(chanEn)));
  p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkFall && ackLineN) |=> ackLineN);
endmodule

bind sbus_ctrl_reg sbus_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chanEn    (chanEn),
  .wrByte    (wrByte),
  .wrData    (wrData),
  .bitWr     (bitWr),
  .bitIdx    (bitIdx),
  .bitVal    (bitVal),
  .xferStart (xferStart),
  .relSeen   (relSeen),
  .cmdSeen   (cmdSeen),
  .addrMiss  (addrMiss),
  .sclkFall  (sclkFall),
  .rdData    (rdData),
  .soLatch   (soLatch),
  .ackLineN  (ackLineN)
);

// File: tb/sbus_ctrl_reg_tb.sv
`timescale 1ns/1ps
module sbus_ctrl_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0, wrByte = 1'b0, bitWr = 1'b0, bitVal = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] bitIdx = '0;
  logic xferStart = 1'b0, relSeen = 1'b0, cmdSeen = 1'b0, addrMiss = 1'b0;
  logic sclkFall = 1'b0, ackDet = 1'b0;
  logic [7:0] rdData;
  logic soLatch, ackLineN;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Expected state, computed from the requirements
  logic mBsye = 0, mAcke = 0, mReld = 0, mCmdd = 0, mSo = 1, mPend = 0, mAct = 0, mAckd = 0;

  always #4 clk = ~clk;

  sbus_ctrl_reg u_dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrByte(wrByte), .wrData(wrData),
    .bitWr(bitWr), .bitIdx(bitIdx), .bitVal(bitVal), .xferStart(xferStart),
    .relSeen(relSeen), .cmdSeen(cmdSeen), .addrMiss(addrMiss), .sclkFall(sclkFall),
    .ackDet(ackDet), .rdData(rdData), .soLatch(soLatch), .ackLineN(ackLineN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead();
    return {mBsye, mAckd, mAcke, 1'b0, mCmdd, mReld, 2'b00};
  endfunction

  task automatic checkAll();
    chk("R8 read bits 6,4,1,0", rdData & 8'h53, expRead() & 8'h53);
    chk("R9 bits 7,5 storage", rdData & 8'hA0, expRead() & 8'hA0);
    chk("R5 release seen", {7'd0, rdData[2]}, {7'd0, mReld});
    chk("R6 command seen", {7'd0, rdData[3]}, {7'd0, mCmdd});
    chk("R2_R3_R4 soLatch", {7'd0, soLatch}, {7'd0, mSo});
    chk("R7_R4 ackLineN", {7'd0, ackLineN}, {7'd0, ~mAct});
  endtask

  // One cycle: check outputs, apply inputs, advance the model
  task automatic cyc(input logic en, input logic wb, input logic [7:0] wd,
                     input logic bw, input logic [2:0] bi, input logic bv,
                     input logic xs, input logic rs, input logic cs,
                     input logic am, input logic sf, input logic ad);
    logic [7:0] mask, val;
    logic rel, cmd, ak;
    @(negedge clk);
    checkAll();
    chanEn = en; wrByte = wb; wrData = wd; bitWr = bw; bitIdx = bi; bitVal = bv;
    xferStart = xs; relSeen = rs; cmdSeen = cs; addrMiss = am; sclkFall = sf; ackDet = ad;
    mask = '0; val = '0;
    if (wb) begin mask = 8'hFF; val = wd; end
    else if (bw) begin mask[bi] = 1'b1; val[bi] = bv; end
    if (mask[7]) mBsye = val[7];
    if (mask[5]) mAcke = val[5];
    rel = en & mask[0] & val[0];
    cmd = en & mask[1] & val[1];
    ak  = en & mask[4] & val[4];
    if (cmd) mSo = 1'b0; else if (rel) mSo = 1'b1;
    mReld = (xs | am | ~en) ? 1'b0 : (rs ? 1'b1 : mReld);
    mCmdd = (xs | rs | ~en) ? 1'b0 : (cs ? 1'b1 : mCmdd);
    if (!en) mAct = 1'b0; else if (sf) mAct = mPend;
    if (!en || xs) mPend = 1'b0; else if (ak) mPend = 1'b1; else if (sf) mPend = 1'b0;
    mAckd = ad;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1,0,0,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic byteWr(input logic en, input logic [7:0] d);
    cyc(en,1,d,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic fall();
    cyc(1,0,0,0,0,0,0,0,0,0,1,0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset rdData", rdData, 8'h00);
    chk("R1 reset soLatch", {7'd0, soLatch}, 8'h01);
    chk("R1 reset ackLineN", {7'd0, ackLineN}, 8'h01);
    rstN = 1'b1;
    idle(2);
    // R2/R3: trigger writes and command-over-release priority
    byteWr(1, 8'h02); byteWr(1, 8'h01); byteWr(1, 8'h03); idle(1);
    cyc(1,0,0,1,3'd0,1,0,0,0,0,0,0);   // bit-set release
    cyc(1,0,0,1,3'd1,0,0,0,0,0,0,0);   // bit-clear command: no effect (R9)
    // R9: byte write beats bit write, storage bits
    cyc(1,1,8'hA0,1,3'd7,0,0,0,0,0,0,0);
    cyc(1,0,0,1,3'd5,0,0,0,0,0,0,0);
    byteWr(1, 8'h4C);                  // R8: read-only bits ignore writes
    // R4: disabled channel ignores triggers, storage still writable
    byteWr(1, 8'h02);
    byteWr(0, 8'h91); byteWr(0, 8'h11); idle(2);
    // R5/R6: detection flags and priorities
    cyc(1,0,0,0,0,0,0,1,1,0,0,0);      // rel+cmd: RELD set, CMDD cleared
    cyc(1,0,0,0,0,0,0,0,1,0,0,1);
    cyc(1,0,0,0,0,0,0,1,0,0,0,0);      // rel clears CMDD
    cyc(1,0,0,0,0,0,0,1,0,1,0,0);      // addrMiss beats rel
    cyc(1,0,0,0,0,0,0,1,1,0,0,0);
    cyc(1,0,0,0,0,0,1,0,1,0,0,0);      // transfer start clears both
    // R7: acknowledge sequence and cancellation
    byteWr(1, 8'h10); idle(2); fall(); idle(3); fall(); idle(2);
    cyc(1,1,8'h10,0,0,0,0,0,0,0,1,0);  // write with fall in same cycle
    fall(); idle(1); fall(); idle(1);
    byteWr(1, 8'h10); cyc(1,0,0,0,0,0,1,0,0,0,0,0); fall(); idle(2);
    byteWr(1, 8'h10); fall(); idle(1); cyc(0,0,0,0,0,0,0,0,0,0,0,0); idle(2);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 20) != 0, ($urandom % 8) == 0, 8'($urandom),
          ($urandom % 6) == 0, 3'($urandom), 1'($urandom),
          ($urandom % 12) == 0, ($urandom % 10) == 0, ($urandom % 8) == 0,
          ($urandom % 12) == 0, ($urandom % 4) == 0, 1'($urandom));
    end
    @(negedge clk);
    checkAll();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule